// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes from a transmit queue into asynchronous serial frames on a single output line. A byte is offered on a valid/ready handshake. The block takes one byte per frame, and only when it is idle. It then sends a start bit, five to eight data bits least-significant first, an optional parity bit and the chosen stop period, all timed by a 16x oversampled tick enable. After the stop period it can hold the line idle for a set number of bit times before it accepts the next byte.

The frame format comes from static configuration inputs:
- word length
- extra stop bits
- parity on or off, with an even/odd choice and a forced-constant ("stick") option
- a break override that drives the line low while the sequencer keeps running
- a programmable inter-frame gap
- optional hardware flow control from a clear-to-send input whose active level can be chosen

A `lineIdle` flag tells the system that the queue is empty and the last stop bit has gone out. The system can use it before it changes the configuration or powers down.

Top module: `serial_frame_tx`

## Requirements
- R1: The line idles at logic 1. A frame begins with one start bit at logic 0, and data bits follow least-significant first. Every bit lasts 16 tick enables.
- R2: The word-length code `cfgWordLen` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper bits of the byte are not sent.
- R3: With `cfgParityEn`=1 and `cfgStickSel`=0, a parity bit follows the data. With `cfgEvenSel`=1 the data bits plus the parity bit hold an even number of ones. With `cfgEvenSel`=0 they hold an odd number.
- R4: With `cfgParityEn`=1 and `cfgStickSel`=1, the parity bit is a constant: 0 when `cfgEvenSel`=1 and 1 when `cfgEvenSel`=0.
- R5: The stop period is at logic 1. With `cfgTwoStop`=0 it lasts 16 ticks. With `cfgTwoStop`=1 it lasts 24 ticks (1.5 bits) for 5-bit words and 32 ticks (2 bits) for 6-, 7- and 8-bit words.
- R6: While `cfgBreak`=1, `txLine` is 0 whatever the frame state. The frame sequencing continues underneath, so the frame ends at its normal time.
- R7: After each stop period the line stays at 1 for `cfgGap` bit times (16 ticks each). During that time `busy` stays 1 and no byte is accepted. With `cfgGap`=0 there is no gap.
- R8: With `cfgFlowEn`=1, no byte is accepted and no frame starts unless `ctsIn` equals `cfgCtsActHigh`. With `cfgFlowEn`=0, `ctsIn` has no effect.
- R9: `lineIdle` is 1 only when no byte is offered (`inValid`=0) and the block is idle, that is, the stop period and any gap of the last frame have ended.
- R10: `inReady` is 1 only while the block is idle and flow control allows it. A byte is taken on a clock edge where `inValid` and `inReady` are both 1. `busy` is 1 from the cycle after that edge until the frame and its gap end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 16x oversampled baud tick enable |
| inData | input | 8 | Byte offered from the queue |
| inValid | input | 1 | Queue has a byte |
| inReady | output | 1 | Block takes the byte at this edge |
| cfgWordLen | input | 2 | Data bits minus five |
| cfgTwoStop | input | 1 | Extra stop period (1.5 or 2 bits) |
| cfgParityEn | input | 1 | Send a parity bit |
| cfgEvenSel | input | 1 | Even parity / stick value select |
| cfgStickSel | input | 1 | Constant parity bit |
| cfgBreak | input | 1 | Force line low |
| cfgGap | input | 8 | Idle bit times between frames |
| cfgFlowEn | input | 1 | Enable clear-to-send gating |
| cfgCtsActHigh | input | 1 | Clear-to-send active level is high |
| ctsIn | input | 1 | Clear-to-send input |
| txLine | output | 1 | Serial output |
| busy | output | 1 | Frame or gap in progress |
| lineIdle | output | 1 | Queue empty and last frame fully sent |

## Verification
Assertions check several rules on every cycle:
- the line is high whenever the block is neither busy nor in break
- every frame opens with a low line
- `lineIdle` never coincides with a low line outside break
- a blocked clear-to-send input keeps the sequencer idle
- the stop tick counter stays inside its longest period
- the data bit index never runs past the selected word length

Only the bench's scenarios can show that frames have the right content and timing: the data bit values, the parity value in every mode, the exact 16/24/32-tick stop lengths, the gap duration, and break masking a frame that still ends on time.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP,
    PH_GAP
  } txPhase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic     load;
    logic     shift;
    txPhase_e phase;
  } txStrobe_t;
endpackage

// File: rtl/sft_ctrl.sv
module sft_ctrl
  import sft_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int GAP_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             inValid,
  output logic             inReady,
  input  logic [1:0]       cfgWordLen,
  input  logic             cfgTwoStop,
  input  logic             cfgParityEn,
  input  logic [GAP_W-1:0] cfgGap,
  input  logic             cfgFlowEn,
  input  logic             cfgCtsActHigh,
  input  logic             ctsIn,
  output txStrobe_t        strobe,
  output logic             busy,
  output logic             lineIdle
);
  localparam int TICK_W = $clog2(2*OVERSAMPLE + 1);
  localparam logic [TICK_W-1:0] LEN_ONE      = TICK_W'(OVERSAMPLE);
  localparam logic [TICK_W-1:0] LEN_ONE_HALF = TICK_W'(OVERSAMPLE + OVERSAMPLE/2);
  localparam logic [TICK_W-1:0] LEN_TWO      = TICK_W'(2*OVERSAMPLE);

  txPhase_e          phase;
  logic [TICK_W-1:0] tickCnt;
  logic [2:0]        bitIdx;
  logic [GAP_W-1:0]  gapCnt;
  logic [TICK_W-1:0] segLen;
  logic [2:0]        lastIdx;
  logic              ctsOk, accept, segEnd, gapLast;

  assign ctsOk   = !cfgFlowEn || (ctsIn == cfgCtsActHigh);
  assign inReady = (phase == PH_IDLE) && ctsOk;
  assign accept  = inValid && inReady;
  assign lastIdx = 3'd4 + {1'b0, cfgWordLen};
  assign gapLast = (gapCnt == cfgGap - GAP_W'(1));

  always_comb begin
    segLen = LEN_ONE;
    if (phase == PH_STOP && cfgTwoStop)
      segLen = (cfgWordLen == 2'd0) ? LEN_ONE_HALF : LEN_TWO;
  end

  assign segEnd = tick && (tickCnt == segLen - TICK_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      gapCnt  <= '0;
    end else if (phase == PH_IDLE) begin
      if (accept) begin
        phase   <= PH_START;
        tickCnt <= '0;
      end
    end else if (tick) begin
      if (!segEnd) begin
        tickCnt <= tickCnt + TICK_W'(1);
      end else begin
        tickCnt <= '0;
        unique case (phase)
          PH_START: begin
            phase  <= PH_DATA;
            bitIdx <= '0;
          end
          PH_DATA: begin
            if (bitIdx == lastIdx) phase <= cfgParityEn ? PH_PARITY : PH_STOP;
            else                   bitIdx <= bitIdx + 3'd1;
          end
          PH_PARITY: phase <= PH_STOP;
          PH_STOP: begin
            gapCnt <= '0;
            phase  <= (cfgGap != '0) ? PH_GAP : PH_IDLE;
          end
          PH_GAP: begin
            if (gapLast) phase <= PH_IDLE;
            else         gapCnt <= gapCnt + GAP_W'(1);
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign strobe.load  = accept;
  assign strobe.shift = (phase == PH_DATA) && segEnd;
  assign strobe.phase = phase;
  assign busy         = (phase != PH_IDLE);
  assign lineIdle     = (phase == PH_IDLE) && !inValid;

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> (bitIdx <= lastIdx)); // R2
  AST_STOP_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STOP) |-> (tickCnt < LEN_TWO)); // R5
  AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFlowEn && (ctsIn != cfgCtsActHigh) && phase == PH_IDLE) |=> (phase == PH_IDLE)); // R8
  AST_START_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(inValid)); // R10
endmodule

// File: rtl/sft_datapath.sv
module sft_datapath
  import sft_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  txStrobe_t         strobe,
  input  logic              cfgEvenSel,
  input  logic              cfgStickSel,
  input  logic              cfgBreak,
  output logic              txLine
);
  logic [DATA_W-1:0] shiftReg;
  logic              parAcc;
  logic              parityBit;
  logic              frameBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= inData;
      parAcc   <= 1'b0;
    end else if (strobe.shift) begin
      parAcc   <= parAcc ^ shiftReg[0];
      shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  // parAcc holds the XOR of the bits actually sent
  assign parityBit = cfgStickSel ? !cfgEvenSel : (cfgEvenSel ? parAcc : !parAcc);

  always_comb begin
    unique case (strobe.phase)
      PH_START:  frameBit = 1'b0;
      PH_DATA:   frameBit = shiftReg[0];
      PH_PARITY: frameBit = parityBit;
      default:   frameBit = 1'b1;
    endcase
  end

  // break masks the line only; the sequencer is untouched
  assign txLine = cfgBreak ? 1'b0 : frameBit;
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int GAP_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  input  logic [1:0]       cfgWordLen,
  input  logic             cfgTwoStop,
  input  logic             cfgParityEn,
  input  logic             cfgEvenSel,
  input  logic             cfgStickSel,
  input  logic             cfgBreak,
  input  logic [GAP_W-1:0] cfgGap,
  input  logic             cfgFlowEn,
  input  logic             cfgCtsActHigh,
  input  logic             ctsIn,
  output logic             txLine,
  output logic             busy,
  output logic             lineIdle
);
  txStrobe_t strobe;

  sft_ctrl #(.OVERSAMPLE(OVERSAMPLE), .GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .inValid(inValid), .inReady(inReady),
    .cfgWordLen(cfgWordLen), .cfgTwoStop(cfgTwoStop), .cfgParityEn(cfgParityEn),
    .cfgGap(cfgGap), .cfgFlowEn(cfgFlowEn), .cfgCtsActHigh(cfgCtsActHigh),
    .ctsIn(ctsIn), .strobe(strobe), .busy(busy), .lineIdle(lineIdle)
  );

  sft_datapath u_datapath (
    .clk(clk), .rstN(rstN), .inData(inData), .strobe(strobe),
    .cfgEvenSel(cfgEvenSel), .cfgStickSel(cfgStickSel), .cfgBreak(cfgBreak),
    .txLine(txLine)
  );

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cfgBreak) |-> txLine); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !cfgBreak) |-> !txLine); // R1
  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (lineIdle && !cfgBreak) |-> txLine); // R9
endmodule

// File: tb/serial_frame_tx_bench.sv
`timescale 1ns/1ps
module serial_frame_tx_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic [7:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [1:0] cfgWordLen = 2'd3;
  logic cfgTwoStop = 1'b0, cfgParityEn = 1'b0, cfgEvenSel = 1'b0, cfgStickSel = 1'b0;
  logic cfgBreak = 1'b0;
  logic [7:0] cfgGap = '0;
  logic cfgFlowEn = 1'b0, cfgCtsActHigh = 1'b0, ctsIn = 1'b1;
  logic txLine, busy, lineIdle;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_frame_tx u_serial_frame_tx (
    .clk(clk), .rstN(rstN), .tick(tick), .inData(inData), .inValid(inValid),
    .inReady(inReady), .cfgWordLen(cfgWordLen), .cfgTwoStop(cfgTwoStop),
    .cfgParityEn(cfgParityEn), .cfgEvenSel(cfgEvenSel), .cfgStickSel(cfgStickSel),
    .cfgBreak(cfgBreak), .cfgGap(cfgGap), .cfgFlowEn(cfgFlowEn),
    .cfgCtsActHigh(cfgCtsActHigh), .ctsIn(ctsIn), .txLine(txLine), .busy(busy),
    .lineIdle(lineIdle)
  );

  // {data[7:0], wordLen[1:0], twoStop, parityEn, evenSel, stickSel}
  localparam int NVEC = 8;
  localparam logic [13:0] VEC [NVEC] = '{
    {8'h55, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hA3, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'hA3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'hFF, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h2C, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h7E, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'h00, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'hFF, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // from segment position 0 (a negedge), check the line mid-segment, end at next position 0
  task automatic checkSeg(input logic exp, input int len, input string tag);
    repeat (len/2) @(negedge clk);
    chk(txLine, exp, tag);
    repeat (len - len/2) @(negedge clk);
  endtask

  // offer a byte, wait for acceptance; returns at position 0 of the start bit
  task automatic sendByte(input logic [7:0] d);
    @(negedge clk);
    inData = d;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runFrame(input logic [13:0] v);
    logic [7:0] d;
    int nb, stopLen;
    logic par;
    d = v[13:6];
    cfgWordLen = v[5:4]; cfgTwoStop = v[3]; cfgParityEn = v[2];
    cfgEvenSel = v[1]; cfgStickSel = v[0];
    nb = 5 + int'(v[5:4]);
    par = 1'b0;
    for (int i = 0; i < nb; i++) par ^= d[i];
    if (v[0]) par = !v[1];             // R4 stick value
    else if (!v[1]) par = !par;        // R3 odd
    stopLen = !v[3] ? 16 : (v[5:4] == 2'd0 ? 24 : 32);
    sendByte(d);
    checkSeg(1'b0, 16, "R1 start bit");
    chk(inReady, 1'b0, "R10 no accept mid-frame");
    chk(busy, 1'b1, "R10 busy during frame");
    for (int i = 0; i < nb; i++) checkSeg(d[i], 16, "R2 data bit");
    if (v[2]) checkSeg(par, 16, v[0] ? "R4 stick parity" : "R3 parity");
    checkSeg(1'b1, stopLen/2, "R5 stop first half");
    chk(busy, 1'b1, "R5 still in stop");
    repeat (stopLen - stopLen/2) @(negedge clk);
    chk(busy, 1'b0, "R5 stop length");
    chk(lineIdle, 1'b1, "R9 line idle after stop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(txLine, 1'b1, "R1 reset line high");
    chk(busy, 1'b0, "R10 reset not busy");
    chk(lineIdle, 1'b1, "R9 reset idle");
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady, 1'b1, "R10 ready when idle");

    // R8: flow control disabled, ctsIn=1 at low active level is ignored
    for (int k = 0; k < NVEC; k++) runFrame(VEC[k]);

    // R6 break during a frame
    cfgWordLen = 2'd3; cfgTwoStop = 0; cfgParityEn = 0; cfgStickSel = 0;
    sendByte(8'hFF);
    cfgBreak = 1'b1;
    checkSeg(1'b0, 16 + 128, "R6 break forces low");
    chk(busy, 1'b1, "R6 sequencer keeps running");
    cfgBreak = 1'b0;
    checkSeg(1'b1, 16, "R6 stop after break");
    chk(lineIdle, 1'b1, "R6 frame ends on time");
    cfgBreak = 1'b1;
    @(negedge clk);
    chk(txLine, 1'b0, "R6 break while idle");
    cfgBreak = 1'b0;

    // R7 gap of two bit times
    cfgGap = 8'd2;
    sendByte(8'h0F);
    checkSeg(1'b0, 16, "R7 start");
    for (int i = 0; i < 8; i++) checkSeg(i < 4, 16, "R7 data");
    checkSeg(1'b1, 16, "R7 stop");
    chk(busy, 1'b1, "R7 busy in gap");
    chk(lineIdle, 1'b0, "R7 not idle in gap");
    chk(inReady, 1'b0, "R7 no accept in gap");
    checkSeg(1'b1, 31, "R7 gap high");
    chk(busy, 1'b1, "R7 gap last cycle");
    @(negedge clk);
    chk(busy, 1'b0, "R7 gap length");
    cfgGap = 8'd0;

    // R8 flow control, active low
    cfgFlowEn = 1'b1; cfgCtsActHigh = 1'b0; ctsIn = 1'b1;
    @(negedge clk);
    inData = 8'h81; inValid = 1'b1;
    repeat (20) @(negedge clk);
    chk(inReady, 1'b0, "R8 blocked low-active");
    chk(busy, 1'b0, "R8 no frame while blocked");
    chk(txLine, 1'b1, "R8 line idle while blocked");
    chk(lineIdle, 1'b0, "R9 byte pending");
    ctsIn = 1'b0;
    runFrame({8'h81, 2'd3, 4'b0000});
    // R8 flow control, active high
    cfgCtsActHigh = 1'b1; ctsIn = 1'b0;
    @(negedge clk);
    inValid = 1'b1;
    repeat (20) @(negedge clk);
    chk(busy, 1'b0, "R8 blocked high-active");
    ctsIn = 1'b1;
    runFrame({8'h3C, 2'd3, 4'b0110});
    cfgFlowEn = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule